// File: doc/BRIEF.md
# In-Order Active List Tracker

The tracker keeps every in-flight instruction in a 32-entry circular list, entered in program order. A rename stage may place up to four instructions in one cycle. Each new instruction is given a 5-bit tag, and that tag is simply its slot number in the list. With each entry the list keeps the logical destination register and the physical register that held that name before the rename. Execution units report a finished instruction by sending its tag back, optionally flagged as faulting. The list storage is split into four banks of eight rows so that four entries can be written in one cycle.

Retirement runs from the oldest entry and takes up to four entries per cycle. It halts at the first entry that has not finished or that carries a fault. Each retired entry's previous physical register goes into an internal 32-deep circular free list. The rename stage draws new registers from that free list, up to four per cycle. When the oldest entry is a faulting one, the tracker stops taking and retiring work. It then replays the stored (logical, previous physical) pairs one per cycle, from the youngest entry down to the faulting one inclusive, so that an external map table can be rewound. After the replay the list is empty.

Top module: `active_list_tracker`

## Requirements
- R1: After reset the list is empty, so no entry retires and no replay is shown. The free list holds physical registers 32 to 63 and hands them out in rising order. A first request for four entries and four registers is granted and yields registers 32, 33, 34 and 35.
- R2: An allocation request (`alloc_req`, 0 to 7) is granted as a whole or not at all. It is granted only when all of these hold: no replay is in progress or starting, `alloc_req` is at most 4, and it is at most 32 minus the number of occupied entries. `alloc_tag` is the tag of slot 0 of the request. Slot k of the request receives tag (`alloc_tag` + k) mod 32.
- R3: A completion on port p with tag t marks entry t as finished, and as faulting when its fault bit is set. The mark is registered, so the entry can retire no earlier than the cycle after the completion.
- R4: `retire_count` is the length of the unbroken run of finished, non-faulting entries starting at the oldest entry, capped at 4 and at the occupancy. `retire_oldp` slot k carries the previous physical register of the entry k places after the oldest.
- R5: Each retired previous physical register is appended to the free list, in retirement order, behind the registers already held there.
- R6: In a cycle where the oldest entry is finished and faulting, no allocation is granted. From the next cycle `rb_valid` is high, and each cycle it shows one entry's `rb_lreg` and `rb_oldp`. The entries run from the newest entry back to the faulting entry inclusive. During the replay nothing retires and no allocation is granted.
- R7: In the cycle after the last replay output, the list is empty. The next granted allocation starts at the faulting entry's tag.
- R8: A free-list request (`take_req`, 0 to 7) is granted only if it is at most 4 and at most the number of registers held before this cycle's pushes. Slot k of `take_preg` is then the k-th oldest register held. A denied request removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 3 | Number of entries wanted this cycle |
| alloc_lreg | input | 20 | Logical destination per slot, 5 bits each, slot 0 lowest |
| alloc_oldp | input | 24 | Previous physical register per slot, 6 bits each |
| alloc_grant | output | 1 | Whole request accepted |
| alloc_tag | output | 5 | Tag given to slot 0 |
| cpl_valid | input | 2 | Completion present, one bit per port |
| cpl_tag | input | 10 | Completed tag per port, 5 bits each |
| cpl_exc | input | 2 | Completion reports a fault, per port |
| retire_count | output | 3 | Entries retiring this cycle |
| retire_oldp | output | 24 | Previous physical register of each retiring slot |
| rb_valid | output | 1 | Replay pair valid |
| rb_lreg | output | 5 | Logical register to rewind |
| rb_oldp | output | 6 | Physical register to restore for it |
| take_req | input | 3 | Number of free registers wanted |
| take_grant | output | 1 | Free-list request accepted |
| take_preg | output | 24 | Granted registers, 6 bits each, slot 0 oldest |

## Verification
The most frequent overlap is retirement at the oldest end happening in the same cycle as allocation at the newest end. The random stimulus keeps the list partly full and requests entries every cycle, so it provokes this overlap constantly. A related overlap is a completion arriving in the same cycle that entries retire, and it tests that the fresh mark waits one cycle. A behavioural model built on a queue and plain arrays predicts the grant, the tag, the retire count, the freed registers and the registers drawn from the free list. Every cycle, those predictions are compared with the ports while both ends of the list move at once.

// File: rtl/alq_pkg.sv
`timescale 1ns/1ps
// Shared types for the active list tracker.
package alq_pkg;
    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_ROLL = 1'b1
    } alq_mode_e;
endpackage

// File: rtl/alq_bank.sv
`timescale 1ns/1ps
// One bank of the active list: ROWS entries, one write port, CPL completion ports.
// Assumes entry e lives in bank e mod WAYS at row e / WAYS, and WAYS is a power of two >= 2.
module alq_bank #(
    parameter int ROWS    = 8,
    parameter int WAYS    = 4,
    parameter int TAG_W   = 5,
    parameter int LREG_W  = 5,
    parameter int PREG_W  = 6,
    parameter int CPL     = 2,
    parameter int BANK_ID = 0,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int BSEL_W = $clog2(WAYS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ROW_W-1:0]         wr_row,
    input  logic [LREG_W-1:0]        wr_lreg,
    input  logic [PREG_W-1:0]        wr_oldp,
    input  logic [CPL-1:0]           cpl_valid,
    input  logic [CPL*TAG_W-1:0]     cpl_tag,
    input  logic [CPL-1:0]           cpl_exc,
    output logic [ROWS*LREG_W-1:0]   rd_lreg,
    output logic [ROWS*PREG_W-1:0]   rd_oldp,
    output logic [ROWS-1:0]          rd_done,
    output logic [ROWS-1:0]          rd_exc
);
    logic [LREG_W-1:0] lreg_q [ROWS];
    logic [PREG_W-1:0] oldp_q [ROWS];
    logic [ROWS-1:0]   done_q;
    logic [ROWS-1:0]   exc_q;

    // Payload storage: written only when an entry is allocated.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            lreg_q[wr_row] <= wr_lreg;
            oldp_q[wr_row] <= wr_oldp;
        end
    end

    // Status bits: completions set them, a fresh allocation clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '0;
            exc_q  <= '0;
        end else begin
            for (int p = 0; p < CPL; p++) begin
                if (cpl_valid[p] &&
                    cpl_tag[p*TAG_W +: BSEL_W] == BSEL_W'(BANK_ID)) begin
                    done_q[cpl_tag[p*TAG_W+BSEL_W +: ROW_W]] <= 1'b1;
                    exc_q[cpl_tag[p*TAG_W+BSEL_W +: ROW_W]]  <= cpl_exc[p];
                end
            end
            if (wr_en) begin
                done_q[wr_row] <= 1'b0;
                exc_q[wr_row]  <= 1'b0;
            end
        end
    end

    // Flatten the rows for the top level.
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            rd_lreg[r*LREG_W +: LREG_W] = lreg_q[r];
            rd_oldp[r*PREG_W +: PREG_W] = oldp_q[r];
        end
        rd_done = done_q;
        rd_exc  = exc_q;
    end

    generate
        for (genvar p = 0; p < CPL; p++) begin : g_cpl_chk
            // R3: a completion never lands on the row being allocated in the same cycle.
            assert_cpl_not_fresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && cpl_valid[p] &&
                 cpl_tag[p*TAG_W +: BSEL_W] == BSEL_W'(BANK_ID))
                |-> (cpl_tag[p*TAG_W+BSEL_W +: ROW_W] != wr_row));
        end
    endgenerate
endmodule

// File: rtl/alq_free_list.sv
`timescale 1ns/1ps
// Circular free list of physical registers: up to WAYS pushes and WAYS pops per cycle.
// Starts full with BASE .. BASE+DEPTH-1; pops see only what was held before this cycle's pushes.
module alq_free_list #(
    parameter int DEPTH  = 32,
    parameter int WAYS   = 4,
    parameter int PREG_W = 6,
    parameter int BASE   = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1,
    localparam int REQ_W = $clog2(WAYS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [REQ_W-1:0]        push_n,
    input  logic [WAYS*PREG_W-1:0]  push_data,
    input  logic [REQ_W-1:0]        pop_req,
    output logic                    pop_grant,
    output logic [WAYS*PREG_W-1:0]  pop_data
);
    logic [PREG_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  popped;

    // Grant a pop only when enough registers were already held.
    always_comb begin
        pop_grant = (pop_req <= REQ_W'(WAYS)) && (CNT_W'(pop_req) <= cnt);
        popped    = pop_grant ? CNT_W'(pop_req) : '0;
        for (int k = 0; k < WAYS; k++)
            pop_data[k*PREG_W +: PREG_W] = mem[rd_ptr + IDX_W'(k)];
    end

    // Pointer, count and storage update; reset loads the initial register set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= CNT_W'(DEPTH);
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= PREG_W'(BASE + i);
        end else begin
            for (int k = 0; k < WAYS; k++)
                if (REQ_W'(k) < push_n)
                    mem[wr_ptr + IDX_W'(k)] <= push_data[k*PREG_W +: PREG_W];
            wr_ptr <= wr_ptr + IDX_W'(push_n);
            rd_ptr <= rd_ptr + IDX_W'(popped);
            cnt    <= cnt + CNT_W'(push_n) - popped;
        end
    end

    // R8: pushes never exceed the room left after this cycle's pops.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt} + (CNT_W+1)'(push_n) - {1'b0, popped}) <= (CNT_W+1)'(DEPTH));
endmodule

// File: rtl/active_list_tracker.sv
`timescale 1ns/1ps
// Active list tracker: banked circular list of in-flight instructions with in-order
// retirement into a free list and newest-first replay of old mappings after a fault.
// Assumes DEPTH is a power of two and a multiple of WAYS; tags equal slot numbers.
module active_list_tracker
    import alq_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int WAYS      = 4,
    parameter int LREG_W    = 5,
    parameter int PREG_W    = 6,
    parameter int CPL       = 2,
    parameter int FREE_BASE = 32,
    localparam int TAG_W    = $clog2(DEPTH),
    localparam int CNT_W    = TAG_W + 1,
    localparam int REQ_W    = $clog2(WAYS + 1),
    localparam int ROWS     = DEPTH / WAYS,
    localparam int ROW_W    = $clog2(ROWS),
    localparam int BSEL_W   = $clog2(WAYS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [REQ_W-1:0]        alloc_req,
    input  logic [WAYS*LREG_W-1:0]  alloc_lreg,
    input  logic [WAYS*PREG_W-1:0]  alloc_oldp,
    output logic                    alloc_grant,
    output logic [TAG_W-1:0]        alloc_tag,
    input  logic [CPL-1:0]          cpl_valid,
    input  logic [CPL*TAG_W-1:0]    cpl_tag,
    input  logic [CPL-1:0]          cpl_exc,
    output logic [REQ_W-1:0]        retire_count,
    output logic [WAYS*PREG_W-1:0]  retire_oldp,
    output logic                    rb_valid,
    output logic [LREG_W-1:0]       rb_lreg,
    output logic [PREG_W-1:0]       rb_oldp,
    input  logic [REQ_W-1:0]        take_req,
    output logic                    take_grant,
    output logic [WAYS*PREG_W-1:0]  take_preg
);
    alq_mode_e         mode;
    logic [TAG_W-1:0]  head, tail, rb_ptr;
    logic [CNT_W-1:0]  occ;
    logic              start_roll;
    logic [REQ_W-1:0]  ret_n;

    logic [LREG_W-1:0] ent_lreg [DEPTH];
    logic [PREG_W-1:0] ent_oldp [DEPTH];
    logic [DEPTH-1:0]  ent_done;
    logic [DEPTH-1:0]  ent_exc;

    logic [ROWS*LREG_W-1:0] bank_lreg [WAYS];
    logic [ROWS*PREG_W-1:0] bank_oldp [WAYS];
    logic [ROWS-1:0]        bank_done [WAYS];
    logic [ROWS-1:0]        bank_exc  [WAYS];

    generate
        for (genvar b = 0; b < WAYS; b++) begin : g_bank
            logic [BSEL_W-1:0] slot;
            logic [TAG_W-1:0]  widx;
            logic              wen;
            // Which request slot lands in this bank this cycle.
            assign slot = BSEL_W'(b) - tail[BSEL_W-1:0];
            assign widx = tail + TAG_W'(slot);
            assign wen  = alloc_grant && (REQ_W'(slot) < alloc_req);

            alq_bank #(
                .ROWS(ROWS), .WAYS(WAYS), .TAG_W(TAG_W), .LREG_W(LREG_W),
                .PREG_W(PREG_W), .CPL(CPL), .BANK_ID(b)
            ) u_bank (
                .clk(clk), .rst_n(rst_n),
                .wr_en(wen), .wr_row(widx[TAG_W-1:BSEL_W]),
                .wr_lreg(alloc_lreg[slot*LREG_W +: LREG_W]),
                .wr_oldp(alloc_oldp[slot*PREG_W +: PREG_W]),
                .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_exc(cpl_exc),
                .rd_lreg(bank_lreg[b]), .rd_oldp(bank_oldp[b]),
                .rd_done(bank_done[b]), .rd_exc(bank_exc[b])
            );

            for (genvar r = 0; r < ROWS; r++) begin : g_row
                // Present bank row r as list entry r*WAYS+b.
                assign ent_lreg[r*WAYS+b] = bank_lreg[b][r*LREG_W +: LREG_W];
                assign ent_oldp[r*WAYS+b] = bank_oldp[b][r*PREG_W +: PREG_W];
                assign ent_done[r*WAYS+b] = bank_done[b][r];
                assign ent_exc[r*WAYS+b]  = bank_exc[b][r];
            end
        end
    endgenerate

    // Count the finished, fault-free run at the oldest end and expose its registers.
    always_comb begin
        logic             stop;
        logic [TAG_W-1:0] idx;
        ret_n = '0;
        stop  = (mode != MODE_RUN);
        for (int k = 0; k < WAYS; k++) begin
            idx = head + TAG_W'(k);
            if (!stop && CNT_W'(k) < occ && ent_done[idx] && !ent_exc[idx])
                ret_n = ret_n + 1'b1;
            else
                stop = 1'b1;
            retire_oldp[k*PREG_W +: PREG_W] = ent_oldp[idx];
        end
    end

    // Fault detection at the oldest entry, allocation decision and replay outputs.
    always_comb begin
        start_roll   = (mode == MODE_RUN) && (occ != '0) && ent_done[head] && ent_exc[head];
        alloc_grant  = (mode == MODE_RUN) && !start_roll &&
                       (alloc_req <= REQ_W'(WAYS)) &&
                       (CNT_W'(alloc_req) <= CNT_W'(DEPTH) - occ);
        alloc_tag    = tail;
        retire_count = ret_n;
        rb_valid     = (mode == MODE_ROLL);
        rb_lreg      = ent_lreg[rb_ptr];
        rb_oldp      = ent_oldp[rb_ptr];
    end

    // Pointer and mode sequencing for normal running and for the replay walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= MODE_RUN;
            head   <= '0;
            tail   <= '0;
            occ    <= '0;
            rb_ptr <= '0;
        end else if (mode == MODE_RUN) begin
            head <= head + TAG_W'(ret_n);
            if (alloc_grant)
                tail <= tail + TAG_W'(alloc_req);
            occ  <= occ + (alloc_grant ? CNT_W'(alloc_req) : '0) - CNT_W'(ret_n);
            if (start_roll) begin
                mode   <= MODE_ROLL;
                rb_ptr <= tail - 1'b1;
            end
        end else begin
            if (rb_ptr == head) begin
                mode <= MODE_RUN;
                tail <= head;
                occ  <= '0;
            end else begin
                rb_ptr <= rb_ptr - 1'b1;
            end
        end
    end

    alq_free_list #(
        .DEPTH(DEPTH), .WAYS(WAYS), .PREG_W(PREG_W), .BASE(FREE_BASE)
    ) u_free (
        .clk(clk), .rst_n(rst_n),
        .push_n(ret_n), .push_data(retire_oldp),
        .pop_req(take_req), .pop_grant(take_grant), .pop_data(take_preg)
    );

    // R2: occupancy never exceeds the list size.
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));
    // R4: never more retirements than occupied entries.
    assert_retire_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(retire_count) <= occ);
    // R6: while replaying, nothing retires and nothing is allocated.
    assert_roll_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid |-> (retire_count == '0 && !alloc_grant));
    // R7: when the replay ends the list is empty.
    assert_empty_after_roll_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rb_valid) |-> (occ == '0 && head == tail));
endmodule

// File: tb/sim_active_list_tracker.sv
`timescale 1ns/1ps
// Bench: behavioural model (arrays plus a queue) compared with the ports every cycle.
module sim_active_list_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  alloc_req = '0;
    logic [19:0] alloc_lreg = '0;
    logic [23:0] alloc_oldp = '0;
    logic        alloc_grant;
    logic [4:0]  alloc_tag;
    logic [1:0]  cpl_valid = '0;
    logic [9:0]  cpl_tag = '0;
    logic [1:0]  cpl_exc = '0;
    logic [2:0]  retire_count;
    logic [23:0] retire_oldp;
    logic        rb_valid;
    logic [4:0]  rb_lreg;
    logic [5:0]  rb_oldp;
    logic [2:0]  take_req = '0;
    logic        take_grant;
    logic [23:0] take_preg;

    always #2.5 clk = ~clk;

    active_list_tracker u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_lreg(alloc_lreg), .alloc_oldp(alloc_oldp),
        .alloc_grant(alloc_grant), .alloc_tag(alloc_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_exc(cpl_exc),
        .retire_count(retire_count), .retire_oldp(retire_oldp),
        .rb_valid(rb_valid), .rb_lreg(rb_lreg), .rb_oldp(rb_oldp),
        .take_req(take_req), .take_grant(take_grant), .take_preg(take_preg)
    );

    int total = 0;
    int fails = 0;
    int cycles = 0;

    // Model state.
    int  m_lreg [32];
    int  m_oldp [32];
    bit  m_done [32];
    bit  m_exc  [32];
    int  head = 0, tail = 0, occ = 0, rbp = 0;
    bit  roll = 0, post_roll = 0;
    int  flq [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // One cycle: drive inputs, predict, compare, advance the model.
    task automatic step(input int cpl_pct, input int exc_pct, input bit first);
        int n, treq, areq;
        bit e_start, e_grant, e_tg, stop;
        int e_ret;
        int cand [$];
        @(negedge clk);
        // Stimulus choice from model state.
        n = ($urandom_range(0, 19) == 0) ? 7 : $urandom_range(0, 4);
        if (first) n = 4;
        e_start = !roll && occ > 0 && m_done[head] && m_exc[head];
        if (n <= 4 && !roll && !e_start && n <= 32 - occ) begin
            if (n <= flq.size()) begin areq = n; treq = n; end
            else begin areq = 0; treq = n; end
        end else begin
            areq = n; treq = (n > 4) ? n : 0;
        end
        alloc_req  = 3'(areq);
        take_req   = 3'(treq);
        alloc_lreg = 20'($urandom());
        alloc_oldp = 24'($urandom());
        cpl_valid  = '0;
        cpl_exc    = '0;
        if (!roll) begin
            for (int i = 0; i < occ; i++)
                if (!m_done[(head + i) % 32]) cand.push_back((head + i) % 32);
            for (int p = 0; p < 2; p++) begin
                if (cand.size() > 0 && $urandom_range(0, 99) < cpl_pct) begin
                    int j;
                    j = $urandom_range(0, cand.size() - 1);
                    cpl_valid[p] = 1'b1;
                    cpl_tag[p*5 +: 5] = 5'(cand[j]);
                    cpl_exc[p] = ($urandom_range(0, 99) < exc_pct);
                    cand.delete(j);
                end
            end
        end
        #1;
        // Predictions.
        e_ret = 0;
        stop  = roll;
        for (int k = 0; k < 4; k++) begin
            int idx;
            idx = (head + k) % 32;
            if (!stop && k < occ && m_done[idx] && !m_exc[idx]) e_ret++;
            else stop = 1;
        end
        e_grant = !roll && !e_start && areq <= 4 && areq <= 32 - occ;
        e_tg    = treq <= 4 && treq <= flq.size();
        // Comparisons.
        chk(alloc_grant == e_grant, first ? "R1" : (e_start ? "R6" : "R2"),
            "alloc_grant", alloc_grant, e_grant);
        if (e_grant && areq > 0)
            chk(alloc_tag == 5'(tail), post_roll ? "R7" : "R2", "alloc_tag", alloc_tag, tail);
        chk(retire_count == 3'(e_ret), first ? "R1" : "R3,R4", "retire_count",
            retire_count, e_ret);
        for (int k = 0; k < e_ret; k++)
            chk(retire_oldp[k*6 +: 6] == 6'(m_oldp[(head + k) % 32]), "R4", "retire_oldp",
                retire_oldp[k*6 +: 6], m_oldp[(head + k) % 32]);
        chk(rb_valid == roll, first ? "R1" : "R6", "rb_valid", rb_valid, roll);
        if (roll) begin
            chk(rb_lreg == 5'(m_lreg[rbp]), "R6", "rb_lreg", rb_lreg, m_lreg[rbp]);
            chk(rb_oldp == 6'(m_oldp[rbp]), "R6", "rb_oldp", rb_oldp, m_oldp[rbp]);
        end
        chk(take_grant == e_tg, "R8", "take_grant", take_grant, e_tg);
        if (e_tg)
            for (int k = 0; k < treq; k++)
                chk(take_preg[k*6 +: 6] == 6'(flq[k]), first ? "R1" : "R5",
                    "take_preg", take_preg[k*6 +: 6], flq[k]);
        // Advance the model.
        if (e_tg) for (int k = 0; k < treq; k++) void'(flq.pop_front());
        for (int k = 0; k < e_ret; k++) flq.push_back(m_oldp[(head + k) % 32]);
        for (int p = 0; p < 2; p++)
            if (cpl_valid[p]) begin
                m_done[cpl_tag[p*5 +: 5]] = 1;
                m_exc[cpl_tag[p*5 +: 5]]  = cpl_exc[p];
            end
        if (e_grant && areq > 0) post_roll = 0;
        if (roll) begin
            if (rbp == head) begin
                tail = head; occ = 0; roll = 0; post_roll = 1;
            end else begin
                rbp = (rbp + 31) % 32;
            end
        end else begin
            if (e_grant)
                for (int k = 0; k < areq; k++) begin
                    int idx;
                    idx = (tail + k) % 32;
                    m_lreg[idx] = alloc_lreg[k*5 +: 5];
                    m_oldp[idx] = alloc_oldp[k*6 +: 6];
                    m_done[idx] = 0;
                    m_exc[idx]  = 0;
                end
            if (e_grant) begin tail = (tail + areq) % 32; occ += areq; end
            head = (head + e_ret) % 32;
            occ -= e_ret;
            if (e_start) begin roll = 1; rbp = (tail + 31) % 32; end
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) flq.push_back(32 + i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 1);                               // R1 reset state and first grants
        repeat (1500) step(60, 0, 0);                // R2 R3 R4 R5 R8 steady traffic
        repeat (200)  step(0, 0, 0);                 // R2 fill the list, requests denied
        repeat (300)  step(95, 0, 0);                // R4 bursts of four retirements
        repeat (3000) step(50, 4, 0);                // R6 R7 faults and replays
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule